// File: doc/BRIEF.md
# Maskable Interrupt Controller

This block gathers a set of interrupt lines into a pending-status register and sends one interrupt request to the processor core. Software uses a small register port to program a mask register, which selects the lines allowed to interrupt. Through the same port it reads the pending bits and clears them.

The two lowest-numbered lines always reach the request, whatever the mask holds. No request is raised at all while the core's global interrupt-enable input is low. A parameter chosen at build time selects one of two modes for every line:

- **Level mode.** A pending bit follows its line. It clears itself when the line falls.
- **Edge mode.** A pending bit is set when the line rises. It stays set until software clears it.

The register port is a plain control interface, not a stream. A write is accepted in the cycle in which the write strobe is high. A read returns its data combinationally from the address. The port never stalls, so it has no back-pressure.

Top module: `irqc_top`

## Requirements
- R1: After reset, the pending register reads 0, the mask register reads 32'h0000_0003, and `irq_o` is 0.
- R2: A write to address 0 loads the mask register. Bits 0 and 1 of the mask always read back as 1, whatever value is written.
- R3: In edge mode, a 0-to-1 change on a line sets that line's pending bit. The bit is readable two rising clock edges after the line change is applied.
- R4: In edge mode, a pending bit stays set after its line falls. After software clears the bit, a line that is held high does not set it again.
- R5: In edge mode, writing 0 to bit n of address 1 clears pending bit n, and writing 1 leaves the bit unchanged. If a new rising edge arrives in the same cycle as the clear, the bit stays set.
- R6: In level mode, pending bit n equals line n as it was two rising edges earlier, and software writes to address 1 have no effect.
- R7: `irq_o` is a register. It becomes the global enable ANDed with the OR over all lines of (pending AND (mask bit OR line index below 2)), one rising edge after those inputs settle.
- R8: While `gie_i` is low, `irq_o` is 0 from the next rising edge onwards.
- R9: Address 0 reads the mask and address 1 reads the pending register. Addresses 2 and 3 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_i | input | 32 | Interrupt lines from the peripherals |
| gie_i | input | 1 | Global interrupt enable from the core |
| bus_wr_i | input | 1 | Write strobe of the register port |
| bus_addr_i | input | 2 | Register address (0 = mask, 1 = pending) |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from `bus_addr_i` |
| irq_o | output | 1 | Registered interrupt request to the core |

## Verification
The assertions assume three things about the inputs: `rst_n` is asserted before the first edge, `line_i` and the bus inputs change only away from the rising edge, and the write strobe is a clean single-cycle level. The edge-mode hold property also assumes that the only way to clear a bit is a write of 0 to address 1. The bench meets these assumptions by driving every input on the falling edge, and by holding each write strobe high for exactly one cycle. The same inputs drive one edge-mode instance and one level-mode instance side by side.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_MASK = 2'd0,
    A_PEND = 2'd1,
    A_RSV2 = 2'd2,
    A_RSV3 = 2'd3
  } irqc_addr_e;

  function automatic logic [31:0] low_ones(input int n);
    logic [31:0] v;
    v = '0;
    for (int k = 0; k < 32; k++)
      if (k < n) v[k] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/irqc_line_sampler.sv
module irqc_line_sampler #(
  parameter int N_LINES = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] line_i,
  output logic [N_LINES-1:0] line_q,
  output logic [N_LINES-1:0] rise_o
);
  logic [N_LINES-1:0] line_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q    <= '0;
      line_prev <= '0;
    end else begin
      line_q    <= line_i;
      line_prev <= line_q;
    end
  end

  assign rise_o = line_q & ~line_prev;
endmodule

// File: rtl/irqc_pending.sv
module irqc_pending #(
  parameter int N_LINES   = 32,
  parameter bit EDGE_MODE = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] line_q,
  input  logic [N_LINES-1:0] rise_i,
  input  logic               clr_en_i,
  input  logic [N_LINES-1:0] clr_keep_i,
  output logic [N_LINES-1:0] pend_o
);
  logic [N_LINES-1:0] pend_q;
  logic [N_LINES-1:0] pend_d;

  generate
    if (EDGE_MODE) begin : g_edge
      always_comb begin
        pend_d = pend_q;
        if (clr_en_i) pend_d = pend_d & clr_keep_i;
        pend_d = pend_d | rise_i;
      end
    end else begin : g_level
      logic unused_lvl;
      assign unused_lvl = clr_en_i ^ (^clr_keep_i) ^ (^rise_i);
      always_comb pend_d = line_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irqc_mask_reg.sv
module irqc_mask_reg #(
  parameter int N_LINES  = 32,
  parameter int N_NOMASK = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [N_LINES-1:0] wdata_i,
  output logic [N_LINES-1:0] mask_o
);
  localparam logic [31:0] FORCED32 = irqc_pkg::low_ones(N_NOMASK);
  localparam logic [N_LINES-1:0] FORCED = FORCED32[N_LINES-1:0];

  logic [N_LINES-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= FORCED;
    else if (wr_en_i) mask_q <= wdata_i | FORCED;
  end

  assign mask_o = mask_q | FORCED;
endmodule

// File: rtl/irqc_req_gen.sv
module irqc_req_gen #(
  parameter int N_LINES = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] pend_i,
  input  logic [N_LINES-1:0] mask_i,
  input  logic               gie_i,
  output logic               irq_o
);
  logic [N_LINES-1:0] hit;
  logic               irq_q;

  genvar g;
  generate
    for (g = 0; g < N_LINES; g++) begin : g_hit
      assign hit[g] = pend_i[g] & mask_i[g];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= gie_i & (|hit);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
  parameter int N_LINES   = 32,
  parameter int N_NOMASK  = 2,
  parameter bit EDGE_MODE = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_LINES-1:0]          line_i,
  input  logic                        gie_i,
  input  logic                        bus_wr_i,
  input  logic [irqc_pkg::ADDR_W-1:0] bus_addr_i,
  input  logic [N_LINES-1:0]          bus_wdata_i,
  output logic [N_LINES-1:0]          bus_rdata_o,
  output logic                        irq_o
);
  import irqc_pkg::*;

  logic [N_LINES-1:0] line_q;
  logic [N_LINES-1:0] rise;
  logic [N_LINES-1:0] status_q;
  logic [N_LINES-1:0] mask_q;
  logic               mask_we;
  logic               pend_we;

  assign mask_we = bus_wr_i && (bus_addr_i == A_MASK);
  assign pend_we = bus_wr_i && (bus_addr_i == A_PEND);

  irqc_line_sampler #(.N_LINES(N_LINES)) u_samp (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i (line_i),
    .line_q (line_q),
    .rise_o (rise)
  );

  irqc_pending #(.N_LINES(N_LINES), .EDGE_MODE(EDGE_MODE)) u_pend (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_q     (line_q),
    .rise_i     (rise),
    .clr_en_i   (pend_we),
    .clr_keep_i (bus_wdata_i),
    .pend_o     (status_q)
  );

  irqc_mask_reg #(.N_LINES(N_LINES), .N_NOMASK(N_NOMASK)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_i (mask_we),
    .wdata_i (bus_wdata_i),
    .mask_o  (mask_q)
  );

  irqc_req_gen #(.N_LINES(N_LINES)) u_req (
    .clk    (clk),
    .rst_n  (rst_n),
    .pend_i (status_q),
    .mask_i (mask_q),
    .gie_i  (gie_i),
    .irq_o  (irq_o)
  );

  always_comb begin
    case (bus_addr_i)
      A_MASK:  bus_rdata_o = mask_q;
      A_PEND:  bus_rdata_o = status_q;
      default: bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int N_LINES   = 32,
  parameter int N_NOMASK  = 2,
  parameter bit EDGE_MODE = 1'b1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_LINES-1:0] line_q,
  input logic [N_LINES-1:0] status_q,
  input logic [N_LINES-1:0] mask_q,
  input logic               gie_i,
  input logic               bus_wr_i,
  input logic [1:0]         bus_addr_i,
  input logic [N_LINES-1:0] bus_wdata_i,
  input logic               irq_o
);
  // R8: enable low forces the request low one edge later
  a_r8_gie_gates: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_i |=> !irq_o);

  // R7: a request needs something pending and allowed in the prior cycle
  a_r7_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(gie_i) && ($past(status_q & mask_q) != '0));

  // R2: non-maskable lines stay enabled in the mask
  a_r2_nomask_ones: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q[N_NOMASK-1:0] == {N_NOMASK{1'b1}});

  genvar i;
  generate
    for (i = 0; i < N_LINES; i++) begin : g_bit
      // R3/R6: a pending bit only rises when its sampled line was high
      a_r3_rise_needs_line: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_q[i]) |-> $past(line_q[i]));
      if (EDGE_MODE) begin : g_e
        // R4: held unless software writes 0 to it
        a_r4_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
          status_q[i] && !(bus_wr_i && bus_addr_i == 2'd1 && !bus_wdata_i[i])
          |=> status_q[i]);
      end else begin : g_l
        // R6: level mode clears when the sampled line is low
        a_r6_level_clear: assert property (@(posedge clk) disable iff (!rst_n)
          !line_q[i] |=> !status_q[i]);
      end
    end
  endgenerate
endmodule

bind irqc_top irqc_checker #(
  .N_LINES(N_LINES), .N_NOMASK(N_NOMASK), .EDGE_MODE(EDGE_MODE)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .line_q      (line_q),
  .status_q    (status_q),
  .mask_q      (mask_q),
  .gie_i       (gie_i),
  .bus_wr_i    (bus_wr_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .irq_o       (irq_o)
);

// File: tb/tb_irqc_top.sv
`timescale 1ns/1ps
module tb_irqc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lines = '0;
  logic        gie = 1'b0;
  logic        wr = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_e, rd_l;
  logic        irq_e, irq_l;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  irqc_top #(.EDGE_MODE(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .line_i(lines), .gie_i(gie),
    .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rd_e), .irq_o(irq_e));

  irqc_top #(.EDGE_MODE(1'b0)) dut_lvl (
    .clk(clk), .rst_n(rst_n), .line_i(lines), .gie_i(gie),
    .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rd_l), .irq_o(irq_l));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a);
    addr = a;
    #1;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    rd(2'd0); chk("R1 mask edge", rd_e, 32'h3); chk("R1 mask lvl", rd_l, 32'h3);
    rd(2'd1); chk("R1 pend edge", rd_e, 0); chk("R1 pend lvl", rd_l, 0);
    chk("R1 irq edge", {31'b0, irq_e}, 0); chk("R1 irq lvl", {31'b0, irq_l}, 0);
    // R9 reserved addresses
    rd(2'd2); chk("R9 addr2", rd_e, 0);
    rd(2'd3); chk("R9 addr3", rd_l, 0);
    wr_reg(2'd2, 32'hFFFF_FFFF);
    wr_reg(2'd3, 32'hFFFF_FFFF);
    rd(2'd0); chk("R9 mask untouched", rd_e, 32'h3);
    rd(2'd1); chk("R9 pend untouched", rd_e, 0);
    // R2 mask write / forced bits
    wr_reg(2'd0, 32'h0);
    rd(2'd0); chk("R2 mask zero", rd_e, 32'h3);
    wr_reg(2'd0, 32'hA5A5_FFF0);
    rd(2'd0); chk("R2 mask pattern", rd_e, 32'hA5A5_FFF3);
    chk("R2 mask pattern lvl", rd_l, 32'hA5A5_FFF3);
    wr_reg(2'd0, 32'h0);
    gie = 1'b1;

    for (int i = 0; i < 32; i++) begin
      lines = 32'h1 << i;
      tick(); tick();
      rd(2'd1);
      chk("R3 edge set", rd_e, 32'h1 << i);
      chk("R6 level set", rd_l, 32'h1 << i);
      tick();
      chk("R7 irq mask0 edge", {31'b0, irq_e}, (i < 2) ? 1 : 0);
      chk("R7 irq mask0 lvl", {31'b0, irq_l}, (i < 2) ? 1 : 0);
      wr_reg(2'd0, 32'h1 << i);
      tick();
      chk("R7 irq unmasked edge", {31'b0, irq_e}, 1);
      chk("R7 irq unmasked lvl", {31'b0, irq_l}, 1);
      lines = '0;
      tick(); tick();
      rd(2'd1);
      chk("R4 edge hold", rd_e, 32'h1 << i);
      chk("R6 level clear", rd_l, 0);
      tick();
      chk("R7 irq lvl drop", {31'b0, irq_l}, 0);
      chk("R7 irq edge stays", {31'b0, irq_e}, 1);
      gie = 1'b0;
      tick();
      chk("R8 gie low", {31'b0, irq_e}, 0);
      gie = 1'b1;
      tick();
      chk("R8 gie back", {31'b0, irq_e}, 1);
      wr_reg(2'd1, ~(32'h1 << i));
      rd(2'd1);
      chk("R5 clear", rd_e, 0);
      tick();
      chk("R5 irq after clear", {31'b0, irq_e}, 0);
      wr_reg(2'd0, 32'h0);
    end

    // R5 writing ones has no effect
    wr_reg(2'd1, 32'hFFFF_FFFF);
    rd(2'd1); chk("R5 write ones", rd_e, 0);
    // R4 no re-queue while held high; R6 level ignores writes
    lines = 32'h80;
    tick(); tick();
    rd(2'd1); chk("R4 set bit7", rd_e, 32'h80);
    wr_reg(2'd1, 32'h0);
    tick(); tick();
    rd(2'd1);
    chk("R4 no requeue", rd_e, 0);
    chk("R6 write ignored", rd_l, 32'h80);
    // R5 set wins over same-cycle clear
    lines = 32'h0;
    tick(); tick();
    lines = 32'h200;
    tick();
    wr_reg(2'd1, 32'h0);
    rd(2'd1);
    chk("R5 set wins", rd_e, 32'h200);
    chk("R6 level follows", rd_l, 32'h200);
    // R7 several lines, one unmasked
    wr_reg(2'd1, 32'h0);
    lines = 32'h0000_0F00;
    tick(); tick();
    wr_reg(2'd0, 32'h0000_0004);
    tick();
    chk("R7 multi masked", {31'b0, irq_e}, 0);
    wr_reg(2'd0, 32'h0000_0400);
    tick();
    chk("R7 multi hit", {31'b0, irq_e}, 1);
    chk("R7 multi hit lvl", {31'b0, irq_l}, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule